// File: doc/BRIEF.md
# SerDes Window Register Access Engine

This block reaches the internal registers of a SerDes PHY that exposes only three 16-bit window registers: a control word, an address word and a data word. A client presents one request at a time on a ready/valid port: a read or write, a 5-bit device number, a 16-bit PHY register address and, for a write, 16-bit data. The engine turns that request into a series of accesses on a memory-mapped register port, polls the busy flag in the control window, and finishes with a one-cycle done pulse carrying read data and an error flag.

The window registers are not directly addressable. Every access to one of them is preceded by a write of a page-select word to a fixed aperture offset. That word is the device number shifted left by seven, ORed with the upper seven bits of the window address. The window register itself then sits inside the aperture at its low nine address bits times four. Busy polling is spaced by a cycle count derived from the clock rate and a fixed time in microseconds. A poll budget bounds how long the engine waits for a stuck PHY.

Top module: `serdes_win_engine`

## Requirements
- R1: Out of reset the engine is idle: `req_ready` is 1, `done` and `rsp_err` are 0 and neither `bus_wr` nor `bus_rd` is asserted.
- R2: In the cycle directly before every window access, the engine writes the page word `(dev << 7) | window_addr[15:9]` to aperture offset `PAGE_OFF` (0x800). For the window registers at 0x80A0..0x80A2 this is `(dev << 7) | 0x40`.
- R3: A window register appears at byte offset `window_addr[8:0] * 4`: control (0x80A0) at 0x280, address (0x80A1) at 0x284, data (0x80A2) at 0x288.
- R4: A read runs: poll control until not busy, write the PHY address to the address window, write control with only bit 0 (start) set (0x0001), poll again until not busy, read the data window; `rsp_rdata` with `done` carries that value.
- R5: A write runs: poll control until not busy, write the PHY address to the address window, write the data to the data window, write control with bit 1 (write select) and bit 0 (start) set (0x0003), then pulses `done` in the next cycle without polling again.
- R6: Control bit 0 read as 1 means busy; while busy, consecutive control reads are spaced exactly `CLK_MHZ*POLL_US + 3` cycles apart.
- R7: After `POLL_LIMIT` consecutive busy readings in one poll, the engine ends the request with `done` and `rsp_err` = 1 and makes no further window access; the next request runs normally.
- R8: `req_ready` is 1 only while idle, a request is accepted on `req_valid` while ready, `done` lasts one cycle, and `rsp_err` is 0 on a request that completes normally.
- R9: `bus_wr` and `bus_rd` are never asserted together, and read data is taken from `bus_rdata` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | DEV_W | PHY device number for the page word |
| req_addr | input | 16 | PHY internal register address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Read result, valid with done |
| rsp_err | output | 1 | Poll budget exhausted, valid with done |
| bus_wr | output | 1 | Single-cycle register write strobe |
| bus_rd | output | 1 | Single-cycle register read request |
| bus_addr | output | ADDR_W | Aperture byte offset |
| bus_wdata | output | DATA_W | Register write data |
| bus_rdata | input | DATA_W | Register read data, one cycle after bus_rd |

## Verification
The bench builds the engine with `CLK_MHZ = 1` and `POLL_US = 4`, giving a four-cycle poll gap so that the exact spacing between control reads is measured in a handful of cycles rather than a thousand. `POLL_LIMIT = 6` makes the timeout path reachable with a responder whose busy flag is held high, and lets the bench count the six polls before the error. A programmable busy duration of twenty cycles makes a read that follows a write find the PHY busy on its first poll, while the write itself completes before the flag clears.

// File: rtl/swin_pkg.sv
`timescale 1ns/1ps
package swin_pkg;

  localparam int WADDR_W = 16;

  localparam logic [WADDR_W-1:0] WIN_CTL = 16'h80A0;
  localparam logic [WADDR_W-1:0] WIN_ADR = 16'h80A1;
  localparam logic [WADDR_W-1:0] WIN_DAT = 16'h80A2;

  localparam int BIT_START = 0;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_WRSEL = 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PAGE,
    PH_XFER,
    PH_RWAIT,
    PH_GAP,
    PH_DONE
  } phase_t;

  typedef enum logic [2:0] {
    SP_POLL_A,
    SP_ADDR,
    SP_DATA,
    SP_CTL,
    SP_POLL_B,
    SP_RDATA
  } step_t;

  function automatic logic [WADDR_W-1:0] step_window(step_t s);
    case (s)
      SP_ADDR:            return WIN_ADR;
      SP_DATA, SP_RDATA:  return WIN_DAT;
      default:            return WIN_CTL;
    endcase
  endfunction

  function automatic logic step_reads(step_t s);
    return (s == SP_POLL_A) || (s == SP_POLL_B) || (s == SP_RDATA);
  endfunction

  function automatic step_t step_after(step_t s, logic is_wr);
    case (s)
      SP_POLL_A: return SP_ADDR;
      SP_ADDR:   return is_wr ? SP_DATA : SP_CTL;
      SP_DATA:   return SP_CTL;
      SP_CTL:    return SP_POLL_B;
      SP_POLL_B: return SP_RDATA;
      default:   return SP_POLL_A;
    endcase
  endfunction

endpackage

// File: rtl/swin_page_map.sv
`timescale 1ns/1ps
module swin_page_map
  import swin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DEV_W  = 5
) (
  input  logic [DEV_W-1:0]   dev,
  input  logic [WADDR_W-1:0] waddr,
  output logic [DATA_W-1:0]  page_word,
  output logic [ADDR_W-1:0]  win_off
);

  localparam int PG_HI_W = 7;
  localparam int OFF_W   = 9;

  logic [DEV_W+PG_HI_W-1:0] page_raw;
  logic [OFF_W+1:0]         off_raw;

  always_comb begin
    page_raw  = {dev, waddr[WADDR_W-1 -: PG_HI_W]};
    off_raw   = {waddr[OFF_W-1:0], 2'b00};
    page_word = DATA_W'(page_raw);
    win_off   = ADDR_W'(off_raw);
  end

endmodule

// File: rtl/swin_gap_timer.sv
`timescale 1ns/1ps
module swin_gap_timer #(
  parameter int CNT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int W = (CNT > 1) ? $clog2(CNT) : 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load || run;
    if (load)
      cnt_d = W'(CNT - 1);
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/swin_poll_budget.sv
`timescale 1ns/1ps
module swin_poll_budget #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || bump;
    if (clr)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/swin_ctrl.sv
`timescale 1ns/1ps
module swin_ctrl
  import swin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DEV_W  = 5,
  parameter logic [ADDR_W-1:0] PAGE_OFF = ADDR_W'('h800)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               bus_wr,
  output logic               bus_rd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic [DEV_W-1:0]   map_dev,
  output logic [WADDR_W-1:0] map_waddr,
  input  logic [DATA_W-1:0]  page_word,
  input  logic [ADDR_W-1:0]  win_off,
  output logic               gap_load,
  output logic               gap_run,
  input  logic               gap_expired,
  output logic               bud_clr,
  output logic               bud_bump,
  input  logic               bud_last
);

  phase_t               ph_q, ph_d;
  step_t                st_q, st_d;
  logic                 wr_q;
  logic [DEV_W-1:0]     dev_q;
  logic [WADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 err_q, err_d;
  logic                 accept;
  logic                 cap_rdata;
  logic [DATA_W-1:0]    window_wdata;

  assign accept    = (ph_q == PH_IDLE) && req_valid;
  assign map_dev   = dev_q;
  assign map_waddr = step_window(st_q);

  // Data written to a window in the transfer phase of a write step.
  always_comb begin
    window_wdata = '0;
    case (st_q)
      SP_ADDR: window_wdata = DATA_W'(addr_q);
      SP_DATA: window_wdata = wdata_q;
      default: begin
        window_wdata[BIT_START] = 1'b1;
        window_wdata[BIT_WRSEL] = wr_q;
      end
    endcase
  end

  // Next-state logic.
  always_comb begin
    ph_d      = ph_q;
    st_d      = st_q;
    err_d     = err_q;
    cap_rdata = 1'b0;
    gap_load  = 1'b0;
    gap_run   = 1'b0;
    bud_clr   = 1'b0;
    bud_bump  = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ph_d    = PH_PAGE;
          st_d    = SP_POLL_A;
          err_d   = 1'b0;
          bud_clr = 1'b1;
        end
      end
      PH_PAGE: begin
        bus_wr    = 1'b1;
        bus_addr  = PAGE_OFF;
        bus_wdata = page_word;
        ph_d      = PH_XFER;
      end
      PH_XFER: begin
        bus_addr = win_off;
        if (step_reads(st_q)) begin
          bus_rd = 1'b1;
          ph_d   = PH_RWAIT;
        end else begin
          bus_wr    = 1'b1;
          bus_wdata = window_wdata;
          if ((st_q == SP_CTL) && wr_q) begin
            ph_d = PH_DONE;
          end else begin
            st_d = step_after(st_q, wr_q);
            ph_d = PH_PAGE;
          end
        end
      end
      PH_RWAIT: begin
        if (st_q == SP_RDATA) begin
          cap_rdata = 1'b1;
          ph_d      = PH_DONE;
        end else if (bus_rdata[BIT_BUSY]) begin
          if (bud_last) begin
            err_d = 1'b1;
            ph_d  = PH_DONE;
          end else begin
            bud_bump = 1'b1;
            gap_load = 1'b1;
            ph_d     = PH_GAP;
          end
        end else begin
          bud_clr = 1'b1;
          st_d    = step_after(st_q, wr_q);
          ph_d    = PH_PAGE;
        end
      end
      PH_GAP: begin
        gap_run = 1'b1;
        if (gap_expired)
          ph_d = PH_PAGE;
      end
      PH_DONE: begin
        ph_d = PH_IDLE;
      end
      default: begin
        ph_d = PH_IDLE;
      end
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      st_q  <= SP_POLL_A;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  // Request capture, enabled on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      dev_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      dev_q   <= req_dev;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Read result, cleared on acceptance, loaded from the data window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (accept)
      rdata_q <= '0;
    else if (cap_rdata)
      rdata_q <= bus_rdata;
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign done      = (ph_q == PH_DONE);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/serdes_win_engine.sv
`timescale 1ns/1ps
module serdes_win_engine
  import swin_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int DEV_W      = 5,
  parameter int CLK_MHZ    = 200,
  parameter int POLL_US    = 5,
  parameter int POLL_LIMIT = 1000,
  parameter logic [ADDR_W-1:0] PAGE_OFF = ADDR_W'('h800)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [15:0]        req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               bus_wr,
  output logic               bus_rd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata
);

  localparam int GAP_CYC = CLK_MHZ * POLL_US;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [DEV_W-1:0]   map_dev;
  logic [WADDR_W-1:0] map_waddr;
  logic [DATA_W-1:0]  page_word;
  logic [ADDR_W-1:0]  win_off;
  logic               gap_load, gap_run, gap_expired;
  logic               bud_clr, bud_bump, bud_last;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  swin_page_map #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEV_W  (DEV_W)
  ) u_page_map (
    .dev       (map_dev),
    .waddr     (map_waddr),
    .page_word (page_word),
    .win_off   (win_off)
  );

  swin_gap_timer #(
    .CNT (GAP_CYC)
  ) u_gap_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (gap_load),
    .run     (gap_run),
    .expired (gap_expired)
  );

  swin_poll_budget #(
    .LIMIT (POLL_LIMIT)
  ) u_poll_budget (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (bud_clr),
    .bump  (bud_bump),
    .last  (bud_last)
  );

  swin_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEV_W    (DEV_W),
    .PAGE_OFF (PAGE_OFF)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_dev     (req_dev),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .done        (done),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .map_dev     (map_dev),
    .map_waddr   (map_waddr),
    .page_word   (page_word),
    .win_off     (win_off),
    .gap_load    (gap_load),
    .gap_run     (gap_run),
    .gap_expired (gap_expired),
    .bud_clr     (bud_clr),
    .bud_bump    (bud_bump),
    .bud_last    (bud_last)
  );

endmodule

// File: rtl/serdes_win_engine_chk.sv
`timescale 1ns/1ps
module serdes_win_engine_chk
  import swin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PAGE_OFF = ADDR_W'('h800)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'({WIN_CTL[8:0], 2'b00});

  logic win_acc;
  logic page_wr;
  assign page_wr = bus_wr && (bus_addr == PAGE_OFF);
  assign win_acc = bus_rd || (bus_wr && (bus_addr != PAGE_OFF));

  // R2: each window access directly follows a page-select write
  assert_page_before_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_acc |-> $past(page_wr));

  // R9: never a read and a write together
  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R8: done is a single-cycle strobe
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: an accepted request makes the engine busy
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1: idle engine keeps the register port quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_wr && !bus_rd));

  // R5: a write-select start is followed at once by done
  assert_write_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == CTL_OFF) && bus_wdata[BIT_WRSEL]) |=> done);

  // R8: after done the engine is ready again
  assert_done_then_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

endmodule

bind serdes_win_engine serdes_win_engine_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PAGE_OFF (PAGE_OFF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/serdes_win_engine_bench.sv
`timescale 1ns/1ps
module serdes_win_engine_bench;

  localparam int AW     = 12;
  localparam int DW     = 16;
  localparam int DVW    = 5;
  localparam int MHZ    = 1;
  localparam int PUS    = 4;
  localparam int LIMIT  = 6;
  localparam int GAP    = MHZ * PUS;
  localparam int LOGN   = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           req_valid, req_ready, req_write;
  logic [DVW-1:0] req_dev;
  logic [15:0]    req_addr;
  logic [DW-1:0]  req_wdata;
  logic           done, rsp_err;
  logic [DW-1:0]  rsp_rdata;
  logic           bus_wr, bus_rd;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  bus_wdata, bus_rdata;

  serdes_win_engine #(
    .ADDR_W(AW), .DATA_W(DW), .DEV_W(DVW),
    .CLK_MHZ(MHZ), .POLL_US(PUS), .POLL_LIMIT(LIMIT)
  ) u_serdes_win_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- behavioural PHY responder ----------------
  int          busy_len = 0;
  bit          stuck    = 1'b0;
  logic [15:0] pg, areg, dreg;
  logic [15:0] mem [0:15];
  int          busy_cnt;
  bit          pend, pend_wr;
  logic [15:0] wa;

  assign wa = {pg[6:0], bus_addr[10:2]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg <= '0; areg <= '0; dreg <= '0; busy_cnt <= 0;
      pend <= 1'b0; pend_wr <= 1'b0; bus_rdata <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1 && pend) begin
          pend <= 1'b0;
          if (pend_wr) mem[areg[3:0]] <= dreg;
          else         dreg <= mem[areg[3:0]];
        end
      end
      if (bus_wr) begin
        if (bus_addr == 12'h800) pg <= bus_wdata;
        else if (wa == 16'h80A1) areg <= bus_wdata;
        else if (wa == 16'h80A2) dreg <= bus_wdata;
        else if (wa == 16'h80A0 && bus_wdata[0]) begin
          if (busy_len == 0) begin
            if (bus_wdata[1]) mem[areg[3:0]] <= dreg;
            else              dreg <= mem[areg[3:0]];
          end else begin
            busy_cnt <= busy_len;
            pend     <= 1'b1;
            pend_wr  <= bus_wdata[1];
          end
        end
      end
      if (bus_rd) begin
        if (wa == 16'h80A0)      bus_rdata <= {15'b0, (busy_cnt != 0) || stuck};
        else if (wa == 16'h80A2) bus_rdata <= dreg;
        else                     bus_rdata <= 16'hDEAD;
      end
    end
  end

  // ---------------- monitor ----------------
  int          n_chk = 0, n_err = 0;
  int          cyc = 0, lg_n = 0, both_cnt = 0, done_cnt = 0;
  bit          lg_rd  [0:LOGN-1];
  int          lg_addr[0:LOGN-1];
  int          lg_dat [0:LOGN-1];
  int          lg_cyc [0:LOGN-1];
  logic [15:0] d_rdata;
  bit          d_err;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if ((bus_wr || bus_rd) && lg_n < LOGN) begin
      lg_rd[lg_n]   = bus_rd;
      lg_addr[lg_n] = int'(bus_addr);
      lg_dat[lg_n]  = int'(bus_wdata);
      lg_cyc[lg_n]  = cyc;
      lg_n          = lg_n + 1;
    end
    if (bus_wr && bus_rd) both_cnt = both_cnt + 1;
    if (done) begin
      d_rdata  = rsp_rdata;
      d_err    = rsp_err;
      done_cnt = done_cnt + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic exp_ent(int i, bit rd, int addr, int data, bit with_data, string tag);
    chk(lg_rd[i] == rd && lg_addr[i] == addr, {tag, " kind/offset"}, lg_addr[i], addr);
    if (with_data) chk(lg_dat[i] == data, {tag, " data"}, lg_dat[i], data);
  endtask

  task automatic do_req(bit wr, logic [4:0] dev, logic [15:0] a, logic [15:0] d, output int base);
    int start, k;
    @(posedge clk); #1;
    base      = lg_n;
    start     = done_cnt;
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready low after accept", int'(req_ready), 0);
    k = 0;
    while (done_cnt == start && k < 3000) begin
      @(posedge clk); #1; k++;
    end
    chk(done_cnt == start + 1, "R8 single done per request", done_cnt - start, 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready out of reset", int'(req_ready), 1);
    chk(done == 1'b0 && rsp_err == 1'b0, "R1 done/err low", int'({done, rsp_err}), 0);
    chk(!bus_wr && !bus_rd, "R1 bus quiet", int'({bus_wr, bus_rd}), 0);
  endtask

  task automatic t_write();
    int b;
    do_req(1'b1, 5'd3, 16'h0005, 16'hBEEF, b);
    chk(lg_n - b == 8, "R5 write access count", lg_n - b, 8);
    for (int j = 0; j < 8; j += 2) exp_ent(b + j, 1'b0, 'h800, 'h1C0, 1'b1, "R2 page word");
    exp_ent(b + 1, 1'b1, 'h280, 0, 1'b0, "R3 control poll");
    exp_ent(b + 3, 1'b0, 'h284, 'h0005, 1'b1, "R3 address window");
    exp_ent(b + 5, 1'b0, 'h288, 'hBEEF, 1'b1, "R3 data window");
    exp_ent(b + 7, 1'b0, 'h280, 'h0003, 1'b1, "R5 control write");
    chk(d_err == 1'b0, "R8 no error on write", int'(d_err), 0);
  endtask

  task automatic t_read();
    int b;
    do_req(1'b0, 5'd3, 16'h0005, 16'h0000, b);
    chk(lg_n - b == 10, "R4 read access count", lg_n - b, 10);
    for (int j = 0; j < 10; j += 2) exp_ent(b + j, 1'b0, 'h800, 'h1C0, 1'b1, "R2 page word");
    exp_ent(b + 1, 1'b1, 'h280, 0, 1'b0, "R4 first poll");
    exp_ent(b + 3, 1'b0, 'h284, 'h0005, 1'b1, "R4 address write");
    exp_ent(b + 5, 1'b0, 'h280, 'h0001, 1'b1, "R4 start only");
    exp_ent(b + 7, 1'b1, 'h280, 0, 1'b0, "R4 second poll");
    exp_ent(b + 9, 1'b1, 'h288, 0, 1'b0, "R4 data read");
    // R9: value returned one cycle after bus_rd reaches rsp_rdata
    chk(d_rdata == 16'hBEEF, "R9 read data", int'(d_rdata), 'hBEEF);
    chk(d_err == 1'b0, "R8 no error on read", int'(d_err), 0);
  endtask

  task automatic t_busy();
    int b, np, last_c;
    busy_len = 20;
    do_req(1'b1, 5'd9, 16'h0007, 16'h1234, b);
    chk(lg_n - b == 8, "R5 write done while PHY busy", lg_n - b, 8);
    do_req(1'b0, 5'd9, 16'h0007, 16'h0000, b);
    np = 0; last_c = 0;
    for (int j = b; j < lg_n; j++) begin
      if (!lg_rd[j] && lg_addr[j] != 'h800) break;
      if (lg_rd[j] && lg_addr[j] == 'h280) begin
        if (np > 0) chk(lg_cyc[j] - last_c == GAP + 3, "R6 poll spacing", lg_cyc[j] - last_c, GAP + 3);
        last_c = lg_cyc[j];
        np++;
      end
    end
    chk(np >= 2, "R6 busy repeats poll", np, 2);
    chk(d_rdata == 16'h1234 && !d_err, "R4 read after busy", int'(d_rdata), 'h1234);
    busy_len = 0;
  endtask

  task automatic t_timeout();
    int b, nctl, nwr;
    stuck = 1'b1;
    do_req(1'b0, 5'd2, 16'h0003, 16'h0000, b);
    nctl = 0; nwr = 0;
    for (int j = b; j < lg_n; j++) begin
      if (lg_rd[j] && lg_addr[j] == 'h280) nctl++;
      if (!lg_rd[j] && lg_addr[j] != 'h800) nwr++;
    end
    chk(d_err == 1'b1, "R7 error flag", int'(d_err), 1);
    chk(nctl == LIMIT, "R7 poll count", nctl, LIMIT);
    chk(nwr == 0, "R7 no window write", nwr, 0);
    stuck = 1'b0;
    do_req(1'b0, 5'd9, 16'h0007, 16'h0000, b);
    chk(d_err == 1'b0 && d_rdata == 16'h1234, "R7 recovery read", int'(d_rdata), 'h1234);
  endtask

  task automatic t_devmax();
    int b;
    do_req(1'b1, 5'd31, 16'hFFFF, 16'hA5A5, b);
    exp_ent(b, 1'b0, 'h800, 'hFC0, 1'b1, "R2 page word top device");
    exp_ent(b + 3, 1'b0, 'h284, 'hFFFF, 1'b1, "R5 full address");
    do_req(1'b0, 5'd31, 16'hFFFF, 16'h0000, b);
    chk(d_rdata == 16'hA5A5, "R4 read top device", int'(d_rdata), 'hA5A5);
    chk(both_cnt == 0, "R9 rd/wr exclusive", both_cnt, 0);
  endtask

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_dev = '0; req_addr = '0; req_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_write();
    t_read();
    t_busy();
    t_timeout();
    t_devmax();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule